// File: doc/BRIEF.md
# Windowed Count-Threshold Binary Filter

This block cleans up a binary pixel stream that arrives in raster order, one pixel per valid cycle, with lines 512 pixels wide. It keeps the four most recently completed lines of the current frame. For every incoming pixel position it counts the set pixels in a 4×4 window taken from those stored lines. The filtered pixel is one when the count is strictly above a programmable threshold. A single count-and-compare step therefore removes isolated noise, as erosion does, and closes small gaps, as dilation does, depending on the threshold.

The window for input column `x` of line `y` covers lines `y-4` to `y-1` and columns `x-2` to `x+1`. Any window position outside the image counts as zero. Each output is registered and leaves one cycle after the pixel that selects its window. The valid, line-start and frame-start strobes are delayed by the same cycle, so a downstream stage sees an unchanged raster. A frame-start pulse wipes the stored lines, so one frame has no effect on the next.

Top module: `bin_window_filter`

## Requirements
- R1: While `rst_n` is low, and on the first edge after it falls, `out_valid`, `out_line_start`, `out_frame_start` and `pix_out` are 0.
- R2: `out_valid`, `out_line_start` and `out_frame_start` equal `pix_valid`, `pix_valid & line_start` and `pix_valid & frame_start` of the previous cycle.
- R3: For the valid input at column x (0..511) of line y, `pix_out` in the next cycle is 1 only if the number of ones at lines y-4..y-1 and columns x-2..x+1 is strictly greater than `thresh`, an unsigned 5-bit value.
- R4: Window positions with a column below 0 or above 511, or a line before line 0 of the current frame, count as 0.
- R5: A valid cycle with `frame_start` high clears all stored lines. No pixel of an earlier frame reaches the output.
- R6: With `thresh` at 16 or more, `pix_out` stays 0. With `thresh` at 0, one set pixel marks every window that contains it.
- R7: `pix_out` is 0 in every cycle where `out_valid` is 0.
- R8: Cycles with `pix_valid` low change no stored line and no column position. Gaps in the stream do not alter any later output.
- R9: Input protocol: `line_start` is high on the first valid pixel of each line. `frame_start` is high only together with `line_start`, on the first pixel of a frame. Each line carries exactly 512 valid pixels. Both strobes are ignored unless `pix_valid` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| thresh | input | 5 | Count threshold; output is 1 when the count exceeds it |
| pix_valid | input | 1 | Input pixel present this cycle |
| line_start | input | 1 | First pixel of a line |
| frame_start | input | 1 | First pixel of a frame |
| pix_in | input | 1 | Binary input pixel |
| out_valid | output | 1 | Filtered pixel present |
| out_line_start | output | 1 | Delayed line-start strobe |
| out_frame_start | output | 1 | Delayed frame-start strobe |
| pix_out | output | 1 | Filtered pixel |

## Verification
The in-module assertions assume the R9 protocol: strobes appear only on valid cycles, and a frame start always coincides with a line start. The bench builds every frame as complete 512-pixel lines, with both strobes on column 0 only. It inserts idle cycles only between pixels and never on a strobe. This keeps the stimulus inside those assumptions while still mixing stalls, threshold extremes and several pixel densities.

// File: rtl/bin_window_filter.sv
module bin_window_filter #(
  parameter int LINE_W = 512,
  parameter int WIN    = 4
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic [$clog2(WIN*WIN+1)-1:0]    thresh,
  input  logic                            pix_valid,
  input  logic                            line_start,
  input  logic                            frame_start,
  input  logic                            pix_in,
  output logic                            out_valid,
  output logic                            out_line_start,
  output logic                            out_frame_start,
  output logic                            pix_out
);
  localparam int CNT_W = $clog2(WIN*WIN+1);
  localparam int IDX_W = $clog2(LINE_W);
  localparam int COL_W = IDX_W + 1;
  localparam int LEFT  = WIN / 2;

  logic              ls, fs;
  logic [LINE_W-1:0] cur;
  logic [LINE_W-1:0] hist [WIN];
  logic [LINE_W-1:0] row  [WIN];
  logic [COL_W-1:0]  col, x;
  logic [CNT_W-1:0]  cnt;

  assign ls = pix_valid & line_start;
  assign fs = pix_valid & frame_start;
  assign x  = ls ? '0 : col;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur <= '0;
      col <= '0;
    end else if (pix_valid) begin
      cur <= {pix_in, cur[LINE_W-1:1]};
      col <= ls ? COL_W'(1) : col + COL_W'(1);
    end
  end

  for (genvar i = 0; i < WIN; i++) begin : g_hist
    always_ff @(posedge clk) begin
      if (!rst_n || fs)
        hist[i] <= '0;
      else if (ls)
        hist[i] <= (i == 0) ? cur : hist[(i == 0) ? 0 : i-1];
    end

    always_comb begin
      if (fs)
        row[i] = '0;
      else if (ls)
        row[i] = (i == 0) ? cur : hist[(i == 0) ? 0 : i-1];
      else
        row[i] = hist[i];
    end
  end

  always_comb begin
    cnt = '0;
    for (int r = 0; r < WIN; r++) begin
      for (int d = 0; d < WIN; d++) begin
        int idx;
        idx = int'(x) + d - LEFT;
        if (idx >= 0 && idx < LINE_W)
          cnt = cnt + CNT_W'(row[r][idx[IDX_W-1:0]]);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid       <= 1'b0;
      out_line_start  <= 1'b0;
      out_frame_start <= 1'b0;
      pix_out         <= 1'b0;
    end else begin
      out_valid       <= pix_valid;
      out_line_start  <= ls;
      out_frame_start <= fs;
      pix_out         <= pix_valid && (cnt > thresh);
    end
  end

  assert_reset_quiet_R1: assert property (@(posedge clk)
    !rst_n |=> !out_valid && !pix_out && !out_line_start && !out_frame_start);

  assert_valid_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    pix_valid |=> out_valid);

  assert_idle_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !pix_valid |=> !out_valid);

  assert_frame_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid && frame_start) |=> !pix_out);

  assert_high_thresh_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid && thresh >= CNT_W'(WIN*WIN)) |=> !pix_out);

  assert_out_gated_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> !pix_out);

  assert_stall_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !pix_valid |=> $stable(col) && $stable(cur));

  assert_strobe_protocol_R9: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |-> line_start && pix_valid);

  assert_frame_strobe_out_R9: assert property (@(posedge clk) disable iff (!rst_n)
    out_frame_start |-> out_line_start);
endmodule

// File: tb/test_bin_window_filter.sv
module test_bin_window_filter;
  localparam int CLK_PERIOD = 10;
  localparam int W = 512;
  localparam int MAXR = 8;

  typedef struct packed {
    logic [4:0]  th;
    logic [2:0]  pat;
    logic [3:0]  rows;
    logic        gap;
    logic [15:0] ones;
  } case_t;

  // pat: 0 zeros, 1 ones, 2 random 1/2, 3 random 1/4, 4 sparse 1/64; ones FFFF = model only
  localparam case_t CASES [0:7] = '{
    '{5'd5,  3'd2, 4'd8, 1'b0, 16'hFFFF},
    '{5'd5,  3'd3, 4'd7, 1'b1, 16'hFFFF},
    '{5'd0,  3'd4, 4'd8, 1'b0, 16'hFFFF},
    '{5'd5,  3'd1, 4'd6, 1'b0, 16'd2047},
    '{5'd15, 3'd1, 4'd6, 1'b0, 16'd1018},
    '{5'd16, 3'd1, 4'd6, 1'b0, 16'd0},
    '{5'd31, 3'd2, 4'd5, 1'b0, 16'd0},
    '{5'd4,  3'd2, 4'd6, 1'b1, 16'hFFFF}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic [4:0] thresh = 5'd5;
  logic pix_valid = 1'b0, line_start = 1'b0, frame_start = 1'b0, pix_in = 1'b0;
  logic out_valid, out_line_start, out_frame_start, pix_out;

  int checks = 0, failures = 0;
  bit done = 1'b0;
  logic [31:0] seed = 32'h1234_5678;
  bit img [0:MAXR-1][0:W-1];

  always #(CLK_PERIOD/2) clk = ~clk;

  bin_window_filter i_bin_window_filter (
    .clk(clk), .rst_n(rst_n), .thresh(thresh), .pix_valid(pix_valid),
    .line_start(line_start), .frame_start(frame_start), .pix_in(pix_in),
    .out_valid(out_valid), .out_line_start(out_line_start),
    .out_frame_start(out_frame_start), .pix_out(pix_out));

  task automatic rnd();
    seed = seed ^ (seed << 13);
    seed = seed ^ (seed >> 17);
    seed = seed ^ (seed << 5);
  endtask

  function automatic bit model(int r, int c, int th);
    int n = 0;
    for (int rr = r - 4; rr < r; rr++)
      for (int cc = c - 2; cc <= c + 1; cc++)
        if (rr >= 0 && cc >= 0 && cc < W) n += int'(img[rr][cc]);
    return n > th;
  endfunction

  task automatic drive(input bit v, input bit ls, input bit fs, input bit p);
    pix_valid = v; line_start = ls; frame_start = fs; pix_in = p;
    @(posedge clk);
    #1;
  endtask

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // R9: full 512-pixel lines, strobes on column 0 only, gaps never on a strobe
  task automatic run_frame(input case_t tc);
    int ones = 0;
    thresh = tc.th;
    for (int r = 0; r < int'(tc.rows); r++)
      for (int c = 0; c < W; c++) begin
        rnd();
        case (tc.pat)
          3'd0: img[r][c] = 1'b0;
          3'd1: img[r][c] = 1'b1;
          3'd2: img[r][c] = seed[7];
          3'd3: img[r][c] = seed[7] & seed[11];
          default: img[r][c] = (seed[13:8] == 6'd0);
        endcase
      end
    for (int r = 0; r < int'(tc.rows); r++)
      for (int c = 0; c < W; c++) begin
        bit e;
        rnd();
        if (tc.gap && c != 0 && seed[3:2] == 2'b00) begin
          drive(1'b0, 1'b0, 1'b0, seed[9]);
          // R7 R8: idle cycle gives no valid output and no set pixel
          check(!out_valid && !pix_out, "R7 R8 idle", {out_valid, pix_out}, 0);
        end
        drive(1'b1, c == 0, r == 0 && c == 0, img[r][c]);
        e = model(r, c, int'(tc.th));
        ones += int'(pix_out);
        // R2 strobes, R3 R4 windowed count with zero borders
        check(out_valid && out_line_start == (c == 0) && out_frame_start == (r == 0 && c == 0),
              "R2 strobes", {out_valid, out_line_start, out_frame_start},
              {1'b1, c == 0, r == 0 && c == 0});
        check(pix_out == e, "R3 R4 window", pix_out, e);
      end
    if (tc.ones != 16'hFFFF)
      check(ones == int'(tc.ones), "R6 R4 ones count", ones, int'(tc.ones));
  endtask

  initial begin
    repeat (CLK_PERIOD * 18000) @(posedge clk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, failures);
      $finish;
    end
  end

  initial begin
    #1;
    repeat (3) @(posedge clk);
    #1;
    // R1: reset state
    check(!out_valid && !pix_out && !out_line_start && !out_frame_start, "R1 reset",
          {out_valid, pix_out, out_line_start, out_frame_start}, 0);
    rst_n = 1'b1;
    drive(1'b0, 1'b0, 1'b0, 1'b0);

    foreach (CASES[k]) run_frame(CASES[k]);

    // R5: bright frame then empty frame at threshold 0 must stay dark
    run_frame('{5'd5, 3'd1, 4'd6, 1'b0, 16'd2047});
    run_frame('{5'd0, 3'd0, 4'd5, 1'b0, 16'd0});

    // R6: threshold 0 with a single pixel gives 16 marked positions
    thresh = 5'd0;
    begin
      int ones = 0;
      for (int r = 0; r < 6; r++)
        for (int c = 0; c < W; c++) begin
          drive(1'b1, c == 0, r == 0 && c == 0, r == 1 && c == 100);
          ones += int'(pix_out);
        end
      check(ones == 16, "R6 single pixel spread", ones, 16);
    end

    // R1: reset mid-stream clears outputs
    rst_n = 1'b0;
    drive(1'b1, 1'b0, 1'b0, 1'b1);
    check(!out_valid && !pix_out, "R1 mid reset", {out_valid, pix_out}, 0);
    rst_n = 1'b1;
    drive(1'b0, 1'b0, 1'b0, 1'b0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, failures);
    $finish;
  end
endmodule